// File: doc/BRIEF.md
# Pixel acquisition timing sequencer

This block generates the per-frame control strobes for the front end of a pixel detector. A run trigger, accepted while the block is idle, starts a frame. Several delays counted in clock ticks (one tick per 10 ns at 100 MHz, so a count of 2400 gives 24 µs) then set the timing. The reset of the charge amplifier is released first. The acquisition window opens next and brackets the two correlated-double-sampling pulses. A serial-readout start strobe follows last. The run trigger drives this analog timing on every frame, so thermal and baseline conditions stay steady.

A second, slower readout trigger is latched until the next frame reaches its readout point, and only that frame requests a readout. On frames without a pending request, the amplifier goes back into reset once the readout delay expires. In both cases a programmable recovery count covers the channel reset before the block accepts another run trigger. A run trigger that arrives while the block is busy is dropped and sets a sticky overrun flag. The configuration inputs must be held steady while busy is high. They must satisfy 1 ≤ r0_dly < acq_dly, and acq_wid and sro_dly must each be at least 1.

Top module: `pix_acq_seq`

## Requirements
- R1: After reset, amp_rst is 1 and acq, cds1, cds2, sro, busy and overrun are all 0.
- R2: A run_trig sampled high while idle sets busy from that edge (edge T). amp_rst falls at edge T+r0_dly.
- R3: acq rises at edge T+acq_dly. cds1 is high for exactly the one cycle that follows that edge.
- R4: acq stays high for acq_wid cycles and falls at edge T+acq_dly+acq_wid. cds2 is high for exactly the one cycle that follows that edge.
- R5: If a readout request is pending, sro rises sro_dly cycles after acq falls. sro stays high until rdo_done is sampled high. At that same edge sro falls and amp_rst rises.
- R6: If no readout request is pending, sro stays 0 for the whole frame. amp_rst rises sro_dly cycles after acq falls.
- R7: A rdo_trig pulse, sampled while idle or earlier in the frame than the readout point, is held until that point and consumed there. Several pulses before one frame give one readout. The following frame has no readout.
- R8: busy falls rec_cnt cycles after the edge where amp_rst rises. A rec_cnt of 0 behaves like 1.
- R9: A run_trig sampled while busy leaves the frame timing unchanged and sets overrun. overrun then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per delay count |
| rst | input | 1 | Synchronous active-high reset |
| run_trig | input | 1 | Run trigger, starts a frame when idle |
| rdo_trig | input | 1 | Readout trigger, marks the next frame for readout |
| r0_dly | input | W | Ticks from trigger to amplifier reset release |
| acq_dly | input | W | Ticks from trigger to window opening |
| acq_wid | input | W | Window length in ticks |
| sro_dly | input | W | Ticks from window close to readout start |
| rec_cnt | input | W | Recovery ticks before returning idle |
| rdo_done | input | 1 | Readout finished |
| amp_rst | output | 1 | Charge amplifier reset, high = in reset |
| acq | output | 1 | Acquisition window |
| cds1 | output | 1 | First correlated sample pulse |
| cds2 | output | 1 | Second correlated sample pulse |
| sro | output | 1 | Serial readout start/active |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky: run trigger arrived while busy |

## Verification
The bench sweeps every small combination of the reset-release delay, window delay, window width, readout delay and recovery count, with and without a pending readout. It compares every output in every cycle of each frame. An off-by-one counter would shift an edge by one cycle, and a sample pulse tied to the wrong edge would show up outside the window. Some frames run with no readout pending, and a design that did not clear the request would start readout on them. A double readout trigger checks that requests merge rather than queue. A trigger sent mid-frame must leave the timing untouched and latch the overrun flag. A recovery count of zero must still give one cycle, and a design that underflowed the count there would hang in recovery.

// File: rtl/pix_acq_pkg.sv
package pix_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_WIN,
    ST_GAP,
    ST_READ,
    ST_RECOV
  } seq_state_t;
endpackage

// File: rtl/pix_rdo_pend.sv
module pix_rdo_pend (
  input  logic clk,
  input  logic rst,
  input  logic rdo_trig,
  input  logic take,
  output logic pend
);
  // a new request on the consuming edge carries over to the next frame
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~take) | rdo_trig;
  end
endmodule

// File: rtl/pix_frame_fsm.sv
module pix_frame_fsm
  import pix_acq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         pend,
  input  logic         rdo_done,
  input  logic [W-1:0] r0_dly,
  input  logic [W-1:0] acq_dly,
  input  logic [W-1:0] acq_wid,
  input  logic [W-1:0] sro_dly,
  input  logic [W-1:0] rec_cnt,
  output logic         take,
  output logic         amp_rst,
  output logic         acq,
  output logic         cds1,
  output logic         cds2,
  output logic         sro,
  output logic         busy
);
  localparam logic [W-1:0] ONE = W'(1);

  seq_state_t   st;
  logic [W-1:0] cnt;

  assign take = (st == ST_GAP) && (cnt == sro_dly) && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      amp_rst <= 1'b1;
      acq     <= 1'b0;
      cds1    <= 1'b0;
      cds2    <= 1'b0;
      sro     <= 1'b0;
      busy    <= 1'b0;
    end else begin
      cds1 <= 1'b0;
      cds2 <= 1'b0;
      cnt  <= cnt + ONE;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_BASE;
            busy <= 1'b1;
            cnt  <= ONE;
          end
        end
        ST_BASE: begin
          if (cnt == r0_dly) amp_rst <= 1'b0;
          if (cnt == acq_dly) begin
            st   <= ST_WIN;
            acq  <= 1'b1;
            cds1 <= 1'b1;
            cnt  <= ONE;
          end
        end
        ST_WIN: begin
          if (cnt == acq_wid) begin
            st   <= ST_GAP;
            acq  <= 1'b0;
            cds2 <= 1'b1;
            cnt  <= ONE;
          end
        end
        ST_GAP: begin
          if (cnt == sro_dly) begin
            if (pend) begin
              st  <= ST_READ;
              sro <= 1'b1;
            end else begin
              st      <= ST_RECOV;
              amp_rst <= 1'b1;
              cnt     <= ONE;
            end
          end
        end
        ST_READ: begin
          if (rdo_done) begin
            st      <= ST_RECOV;
            sro     <= 1'b0;
            amp_rst <= 1'b1;
            cnt     <= ONE;
          end
        end
        ST_RECOV: begin
          if (cnt >= rec_cnt) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_acq_seq.sv
module pix_acq_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_trig,
  input  logic         rdo_trig,
  input  logic [W-1:0] r0_dly,
  input  logic [W-1:0] acq_dly,
  input  logic [W-1:0] acq_wid,
  input  logic [W-1:0] sro_dly,
  input  logic [W-1:0] rec_cnt,
  input  logic         rdo_done,
  output logic         amp_rst,
  output logic         acq,
  output logic         cds1,
  output logic         cds2,
  output logic         sro,
  output logic         busy,
  output logic         overrun
);
  logic pend;
  logic take;

  pix_rdo_pend i_pend (
    .clk      (clk),
    .rst      (rst),
    .rdo_trig (rdo_trig),
    .take     (take),
    .pend     (pend)
  );

  pix_frame_fsm #(.W(W)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (run_trig),
    .pend     (pend),
    .rdo_done (rdo_done),
    .r0_dly   (r0_dly),
    .acq_dly  (acq_dly),
    .acq_wid  (acq_wid),
    .sro_dly  (sro_dly),
    .rec_cnt  (rec_cnt),
    .take     (take),
    .amp_rst  (amp_rst),
    .acq      (acq),
    .cds1     (cds1),
    .cds2     (cds2),
    .sro      (sro),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else     overrun <= overrun | (run_trig & busy);
  end
endmodule

// File: rtl/pix_acq_chk.sv
module pix_acq_chk (
  input logic clk,
  input logic rst,
  input logic run_trig,
  input logic rdo_done,
  input logic amp_rst,
  input logic acq,
  input logic cds1,
  input logic cds2,
  input logic sro,
  input logic busy,
  input logic overrun
);
  a_r2_integrating_at_open: assert property (@(posedge clk) disable iff (rst)
    $rose(acq) |-> !amp_rst);
  a_r3_cds1_at_open: assert property (@(posedge clk) disable iff (rst)
    $rose(acq) |-> cds1);
  a_r3_cds1_inside_window: assert property (@(posedge clk) disable iff (rst)
    cds1 |-> acq);
  a_r4_cds2_at_close: assert property (@(posedge clk) disable iff (rst)
    $fell(acq) |-> cds2);
  a_r4_cds2_outside_window: assert property (@(posedge clk) disable iff (rst)
    cds2 |-> !acq);
  a_r5_done_ends_readout: assert property (@(posedge clk) disable iff (rst)
    (sro && rdo_done) |=> (!sro && amp_rst));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (amp_rst && !acq && !sro));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  a_r9_overrun_on_busy_trig: assert property (@(posedge clk) disable iff (rst)
    (run_trig && busy) |=> overrun);
endmodule

bind pix_acq_seq pix_acq_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .run_trig (run_trig),
  .rdo_done (rdo_done),
  .amp_rst  (amp_rst),
  .acq      (acq),
  .cds1     (cds1),
  .cds2     (cds2),
  .sro      (sro),
  .busy     (busy),
  .overrun  (overrun)
);

// File: tb/test_pix_acq_seq.sv
module test_pix_acq_seq;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_trig = 1'b0, rdo_trig = 1'b0, rdo_done = 1'b0;
  logic [W-1:0] r0_dly = 1, acq_dly = 2, acq_wid = 1, sro_dly = 1, rec_cnt = 1;
  logic amp_rst, acq, cds1, cds2, sro, busy, overrun;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pix_acq_seq #(.W(W)) i_pix_acq_seq (
    .clk(clk), .rst(rst), .run_trig(run_trig), .rdo_trig(rdo_trig),
    .r0_dly(r0_dly), .acq_dly(acq_dly), .acq_wid(acq_wid),
    .sro_dly(sro_dly), .rec_cnt(rec_cnt), .rdo_done(rdo_done),
    .amp_rst(amp_rst), .acq(acq), .cds1(cds1), .cds2(cds2),
    .sro(sro), .busy(busy), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // One frame. Cycle k is sampled at the negedge after trigger edge T+k.
  // daq_k / ovr_k >= 0 pulse rdo_trig / run_trig in that cycle.
  task automatic frame(input int r0, input int a, input int w, input int s,
                       input int rc, input bit pre, input int daq_k,
                       input int ovr_k, input bit exp_ovr);
    int e, d, bend, rce;
    bit pend;
    pend = pre || (daq_k >= 0);
    rce  = (rc < 1) ? 1 : rc;
    d    = a + w + s + 2;
    e    = pend ? d : a + w + s;
    bend = e + rce;
    r0_dly = W'(r0); acq_dly = W'(a); acq_wid = W'(w);
    sro_dly = W'(s); rec_cnt = W'(rc);
    if (pre) begin
      @(negedge clk); rdo_trig = 1'b1;
      @(negedge clk); rdo_trig = 1'b0;
    end
    @(negedge clk); run_trig = 1'b1;
    for (int k = 0; k <= bend + 1; k++) begin
      @(negedge clk);
      run_trig = (k == ovr_k);
      rdo_trig = (k == daq_k);
      chk("R2 busy", busy, k < bend);
      chk("R8 busy", busy, k < bend);
      chk("R2 amp_rst", amp_rst, !(k >= r0 && k < e));
      chk("R3 acq", acq, k >= a && k < a + w);
      chk("R3 cds1", cds1, k == a);
      chk("R4 cds2", cds2, k == a + w);
      chk(pend ? "R5 sro" : "R6 sro", sro, pend && k >= a + w + s && k < d);
      chk("R9 overrun", overrun, exp_ovr && ovr_k >= 0 ? (k > ovr_k) : exp_ovr);
      rdo_done = pend && (k == d - 1);
    end
    run_trig = 1'b0; rdo_trig = 1'b0; rdo_done = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 amp_rst", amp_rst, 1'b1);
    chk("R1 acq", acq, 1'b0);
    chk("R1 cds1", cds1, 1'b0);
    chk("R1 cds2", cds2, 1'b0);
    chk("R1 sro", sro, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 overrun", overrun, 1'b0);

    // sweep; pend frames are followed by non-pend frames (R7 clearing)
    for (int r0 = 1; r0 <= 3; r0++)
      for (int a = r0 + 1; a <= r0 + 2; a++)
        for (int w = 1; w <= 3; w++)
          for (int s = 1; s <= 2; s++)
            for (int rc = 1; rc <= 2; rc++)
              for (int p = 1; p >= 0; p--)
                frame(r0, a, w, s, rc, p[0], -1, -1, 1'b0);

    // R7 merge: two readout pulses, one readout, next frame none
    @(negedge clk); rdo_trig = 1'b1;
    @(negedge clk); rdo_trig = 1'b0;
    frame(2, 4, 2, 2, 1, 1'b1, -1, -1, 1'b0);
    frame(2, 4, 2, 2, 1, 1'b0, -1, -1, 1'b0);
    // R7 request arriving inside the frame before the readout point
    frame(1, 3, 2, 2, 1, 1'b0, 1, -1, 1'b0);
    frame(1, 3, 2, 2, 1, 1'b0, -1, -1, 1'b0);
    // R8 zero recovery behaves as one
    frame(1, 2, 1, 1, 0, 1'b0, -1, -1, 1'b0);
    frame(1, 2, 1, 1, 0, 1'b1, -1, -1, 1'b0);
    // R9 trigger while busy: timing unchanged, overrun latched and sticky
    frame(2, 4, 3, 2, 2, 1'b1, -1, 3, 1'b1);
    frame(1, 3, 1, 1, 1, 1'b0, -1, -1, 1'b1);
    // R1 reset clears overrun
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 overrun cleared", overrun, 1'b0);
    chk("R1 busy cleared", busy, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule